// File: doc/BRIEF.md
# Delayed Read Termination Handler

This block supervises one delayed read after it has been queued toward the target bus. It asks for a bus attempt and reads back how that attempt ended. It keeps asking again until the read has a final outcome. Meanwhile, an initiator that comes back for the data is told to retry. Once an outcome is known, the block holds a response code for the initiator. That code depends on the target's ending, on whether the read is prefetchable, and on whether the initiator asked for more DWORDs than the target delivered. The entry is released when the initiator collects the code.

The retry budget is the parameter `RETRY_LIMIT`, which defaults to 2^24 and can be made small for simulation. When the budget runs out, the entry is dropped. A one-cycle system-error pulse is raised only when the error-enable configuration bit is set and the non-delivery disable bit is clear. A target abort sets two sticky flags: one on the target-facing side when the abort is received, and one on the initiator-facing side when the abort is handed back to the initiator.

States:
- IDLE: no read is held. An accepted `rd_start` moves the block to ISSUE.
- ISSUE: `att_launch` is high for one cycle, then the block moves to WAIT.
- WAIT: the block waits for `att_valid`.
  - A final outcome moves it to HOLD.
  - A retry outcome with budget left moves it back to ISSUE.
  - A retry outcome that uses the last attempt moves it to GIVEUP.
- HOLD: the final code is presented. `ini_query` moves the block to IDLE.
- GIVEUP: lasts one cycle, then the block moves to IDLE.

Top module: `drc_term_handler`

## Requirements
- R1: After reset, `ini_resp` is NONE (0), and `att_launch`, `entry_free`, `serr_out`, `st_rcv_tabort` and `st_sig_tabort` are all 0.
- R2: An accepted `rd_start` gives a one-cycle `att_launch` in the next cycle. A retry outcome gives another one-cycle `att_launch` in the cycle after the outcome is taken. Retry outcomes are:
  - `att_term` RETRY (1);
  - NORMAL (0) or DISCONNECT (2) with `att_dw` = 0;
  - the unused codes 5 to 7.
- R3: Three kinds of outcome are final and end all further launches:
  - NORMAL or DISCONNECT with `att_dw` of at least 1;
  - MASTER ABORT (3);
  - TARGET ABORT (4).
- R4: After NORMAL on a prefetchable read, the code is DISCONNECT (3) if the requested DWORD count is greater than `att_dw`. Otherwise it is DONE (2).
- R5: After NORMAL on a non-prefetchable read, the code is DISCONNECT (3) whatever the counts are.
- R6: After DISCONNECT with data, the code is DISCONNECT (3) if the requested count is greater than `att_dw`. Otherwise it is DONE (2).
- R7: TARGET ABORT gives code TABORT (4) and sets `st_rcv_tabort` in the cycle after the outcome. Collecting that code sets `st_sig_tabort` in the next cycle. Both flags stay set until the next accepted `rd_start` clears them.
- R8: MASTER ABORT gives code MABORT (5). Collecting it pulses `entry_free`, and the block returns to NONE.
- R9: After `RETRY_LIMIT` retry outcomes in a row, no launch follows. Instead, one cycle shows `entry_free` = 1 with NONE. `serr_out` is 1 in that cycle only if `cfg_serr_en` = 1 and `cfg_nodeliv_dis` = 0.
- R10: `ini_resp` is RETRY (1) from acceptance until the outcome. A final code is held unchanged until `ini_query`. The query pulses `entry_free` in that same cycle and returns the block to NONE.
- R11: `rd_start` is ignored unless the block is idle, and `att_valid` is ignored unless the block is waiting for an outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_start | input | 1 | Queue a new delayed read |
| rd_req_dw | input | DW_W | DWORDs requested by the initiator |
| rd_prefetch | input | 1 | Read is prefetchable |
| att_launch | output | 1 | Run one attempt on the target bus |
| att_valid | input | 1 | Attempt outcome is present |
| att_term | input | 3 | Attempt ending: 0 normal, 1 retry, 2 disconnect, 3 master abort, 4 target abort |
| att_dw | input | DW_W | DWORDs moved in the attempt |
| ini_query | input | 1 | Initiator collects the final code |
| cfg_serr_en | input | 1 | System-error enable |
| cfg_nodeliv_dis | input | 1 | Suppress non-delivery system error |
| ini_resp | output | 3 | 0 none, 1 retry, 2 done, 3 disconnect, 4 target abort, 5 master abort |
| entry_free | output | 1 | Entry released this cycle |
| serr_out | output | 1 | System-error pulse |
| st_rcv_tabort | output | 1 | Target-side received-abort flag |
| st_sig_tabort | output | 1 | Initiator-side signaled-abort flag |

## Verification
The checker watches every cycle for a set of rules:
- launch pulses last exactly one cycle and occur only while the code reads RETRY;
- a final code holds steady until it is collected;
- the system error appears only under the configuration gate and together with a release;
- the received-abort flag is sticky;
- the signaled-abort flag never appears without the received-abort flag.

Some behaviour only the bench's scenarios can show:
- the choice between DONE and DISCONNECT for the prefetch and count combinations;
- exactly when the retry budget runs out;
- that stray `rd_start` and `att_valid` inputs have no effect.

The bench shows these through a behavioural model that it compares on every clock.

// File: rtl/drc_pkg.sv
`timescale 1ns/1ps
package drc_pkg;
    typedef enum logic [2:0] {
        TERM_NORMAL = 3'd0,
        TERM_RETRY  = 3'd1,
        TERM_DISC   = 3'd2,
        TERM_MABORT = 3'd3,
        TERM_TABORT = 3'd4
    } term_e;

    typedef enum logic [2:0] {
        RSP_NONE   = 3'd0,
        RSP_RETRY  = 3'd1,
        RSP_DONE   = 3'd2,
        RSP_DISC   = 3'd3,
        RSP_TABORT = 3'd4,
        RSP_MABORT = 3'd5
    } resp_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ISSUE  = 3'd1,
        ST_WAIT   = 3'd2,
        ST_HOLD   = 3'd3,
        ST_GIVEUP = 3'd4
    } state_e;
endpackage

// File: rtl/drc_attempt_ctr.sv
`timescale 1ns/1ps
module drc_attempt_ctr #(
    parameter int LIMIT = 1 << 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc && !last) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // high while the next retry outcome would exhaust the budget
    assign last = (cnt_q == CNT_W'(LIMIT - 1));
endmodule

// File: rtl/drc_resp_pick.sv
`timescale 1ns/1ps
module drc_resp_pick
    import drc_pkg::*;
#(
    parameter int DW_W = 8
) (
    input  logic [2:0]      term,
    input  logic [DW_W-1:0] rd_dw,
    input  logic [DW_W-1:0] req_dw,
    input  logic            prefetch,
    output logic            is_final,
    output resp_e           code
);
    logic got_data;
    logic want_more;

    assign got_data  = (rd_dw != '0);
    assign want_more = (req_dw > rd_dw);

    always_comb begin
        is_final = 1'b0;
        code     = RSP_RETRY;
        unique case (term)
            TERM_NORMAL: begin
                is_final = got_data;
                if (!prefetch || want_more) code = RSP_DISC;
                else                        code = RSP_DONE;
            end
            TERM_DISC: begin
                is_final = got_data;
                code     = want_more ? RSP_DISC : RSP_DONE;
            end
            TERM_MABORT: begin
                is_final = 1'b1;
                code     = RSP_MABORT;
            end
            TERM_TABORT: begin
                is_final = 1'b1;
                code     = RSP_TABORT;
            end
            default: begin
                is_final = 1'b0;
                code     = RSP_RETRY;
            end
        endcase
    end
endmodule

// File: rtl/drc_abort_flags.sv
`timescale 1ns/1ps
module drc_abort_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic set_rcv,
    input  logic set_sig,
    output logic rcv,
    output logic sig
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rcv <= 1'b0;
            sig <= 1'b0;
        end else begin
            if (clr)          rcv <= 1'b0;
            else if (set_rcv) rcv <= 1'b1;
            if (clr)          sig <= 1'b0;
            else if (set_sig) sig <= 1'b1;
        end
    end
endmodule

// File: rtl/drc_term_handler.sv
`timescale 1ns/1ps
module drc_term_handler
    import drc_pkg::*;
#(
    parameter int DW_W        = 8,
    parameter int RETRY_LIMIT = 1 << 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_start,
    input  logic [DW_W-1:0] rd_req_dw,
    input  logic            rd_prefetch,
    output logic            att_launch,
    input  logic            att_valid,
    input  logic [2:0]      att_term,
    input  logic [DW_W-1:0] att_dw,
    input  logic            ini_query,
    input  logic            cfg_serr_en,
    input  logic            cfg_nodeliv_dis,
    output logic [2:0]      ini_resp,
    output logic            entry_free,
    output logic            serr_out,
    output logic            st_rcv_tabort,
    output logic            st_sig_tabort
);
    state_e          st_q, st_d;
    logic [DW_W-1:0] req_q;
    logic            pf_q;
    resp_e           code_q;

    logic  start_acc;
    logic  att_take;
    logic  pick_final;
    resp_e pick_code;
    logic  retry_evt;
    logic  at_limit;

    assign start_acc = (st_q == ST_IDLE) && rd_start;
    assign att_take  = (st_q == ST_WAIT) && att_valid;
    assign retry_evt = att_take && !pick_final;

    drc_resp_pick #(.DW_W(DW_W)) u_pick (
        .term     (att_term),
        .rd_dw    (att_dw),
        .req_dw   (req_q),
        .prefetch (pf_q),
        .is_final (pick_final),
        .code     (pick_code)
    );

    drc_attempt_ctr #(.LIMIT(RETRY_LIMIT)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start_acc),
        .inc   (retry_evt),
        .last  (at_limit)
    );

    drc_abort_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (start_acc),
        .set_rcv (att_take && pick_final && (pick_code == RSP_TABORT)),
        .set_sig ((st_q == ST_HOLD) && ini_query && (code_q == RSP_TABORT)),
        .rcv     (st_rcv_tabort),
        .sig     (st_sig_tabort)
    );

    // next-state decision
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (rd_start) st_d = ST_ISSUE;
            ST_ISSUE:  st_d = ST_WAIT;
            ST_WAIT: begin
                if (att_valid) begin
                    if (pick_final)    st_d = ST_HOLD;
                    else if (at_limit) st_d = ST_GIVEUP;
                    else               st_d = ST_ISSUE;
                end
            end
            ST_HOLD:   if (ini_query) st_d = ST_IDLE;
            ST_GIVEUP: st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // state register and per-read context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            req_q  <= '0;
            pf_q   <= 1'b0;
            code_q <= RSP_NONE;
        end else begin
            st_q <= st_d;
            if (start_acc) begin
                req_q <= rd_req_dw;
                pf_q  <= rd_prefetch;
            end
            if (att_take && pick_final) code_q <= pick_code;
        end
    end

    // outputs
    always_comb begin
        att_launch = 1'b0;
        ini_resp   = RSP_NONE;
        entry_free = 1'b0;
        serr_out   = 1'b0;
        unique case (st_q)
            ST_IDLE:  ini_resp = RSP_NONE;
            ST_ISSUE: begin
                att_launch = 1'b1;
                ini_resp   = RSP_RETRY;
            end
            ST_WAIT:  ini_resp = RSP_RETRY;
            ST_HOLD: begin
                ini_resp   = code_q;
                entry_free = ini_query;
            end
            ST_GIVEUP: begin
                entry_free = 1'b1;
                serr_out   = cfg_serr_en && !cfg_nodeliv_dis;
            end
            default:  ini_resp = RSP_NONE;
        endcase
    end
endmodule

// File: rtl/drc_checker.sv
`timescale 1ns/1ps
module drc_checker
    import drc_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       rd_start,
    input logic       ini_query,
    input logic       cfg_serr_en,
    input logic       cfg_nodeliv_dis,
    input logic       att_launch,
    input logic [2:0] ini_resp,
    input logic       entry_free,
    input logic       serr_out,
    input logic       st_rcv_tabort,
    input logic       st_sig_tabort
);
    p_launch_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        att_launch |=> !att_launch);

    p_launch_retry_r10: assert property (@(posedge clk) disable iff (!rst_n)
        att_launch |-> (ini_resp == RSP_RETRY));

    p_final_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((ini_resp >= RSP_DONE) && !ini_query) |=> $stable(ini_resp));

    p_free_then_none_r8: assert property (@(posedge clk) disable iff (!rst_n)
        entry_free |=> (ini_resp == RSP_NONE));

    p_serr_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        serr_out |-> (cfg_serr_en && !cfg_nodeliv_dis && entry_free));

    p_rcv_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_rcv_tabort && !rd_start) |=> st_rcv_tabort);

    p_sig_needs_rcv_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_sig_tabort |-> st_rcv_tabort);
endmodule

bind drc_term_handler drc_checker u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .rd_start        (rd_start),
    .ini_query       (ini_query),
    .cfg_serr_en     (cfg_serr_en),
    .cfg_nodeliv_dis (cfg_nodeliv_dis),
    .att_launch      (att_launch),
    .ini_resp        (ini_resp),
    .entry_free      (entry_free),
    .serr_out        (serr_out),
    .st_rcv_tabort   (st_rcv_tabort),
    .st_sig_tabort   (st_sig_tabort)
);

// File: tb/test_drc_term_handler.sv
`timescale 1ns/1ps
module test_drc_term_handler;
    localparam int DW  = 8;
    localparam int LIM = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_start = 1'b0;
    logic [DW-1:0] rd_req_dw = '0;
    logic          rd_prefetch = 1'b0;
    logic          att_launch;
    logic          att_valid = 1'b0;
    logic [2:0]    att_term = 3'd0;
    logic [DW-1:0] att_dw = '0;
    logic          ini_query = 1'b0;
    logic          cfg_serr_en = 1'b1;
    logic          cfg_nodeliv_dis = 1'b0;
    logic [2:0]    ini_resp;
    logic          entry_free;
    logic          serr_out;
    logic          st_rcv_tabort;
    logic          st_sig_tabort;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    drc_term_handler #(.DW_W(DW), .RETRY_LIMIT(LIM)) i_drc_term_handler (
        .clk(clk), .rst_n(rst_n), .rd_start(rd_start), .rd_req_dw(rd_req_dw),
        .rd_prefetch(rd_prefetch), .att_launch(att_launch), .att_valid(att_valid),
        .att_term(att_term), .att_dw(att_dw), .ini_query(ini_query),
        .cfg_serr_en(cfg_serr_en), .cfg_nodeliv_dis(cfg_nodeliv_dis),
        .ini_resp(ini_resp), .entry_free(entry_free), .serr_out(serr_out),
        .st_rcv_tabort(st_rcv_tabort), .st_sig_tabort(st_sig_tabort)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural model: phase 0 idle, 1 launch, 2 waiting, 3 holding code, 4 dropped
    int m_ph = 0, m_tries = 0, m_code = 0, m_req = 0;
    bit m_pf = 0, m_rcv = 0, m_sig = 0;

    function automatic int want_code(int term, int dw, int req, bit pf);
        if (term == 3) return 5;
        if (term == 4) return 4;
        if ((term == 0 || term == 2) && dw > 0) begin
            if (term == 0 && !pf) return 3;
            return (req > dw) ? 3 : 2;
        end
        return -1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph <= 0; m_tries <= 0; m_code <= 0; m_rcv <= 0; m_sig <= 0;
        end else begin
            case (m_ph)
                0: if (rd_start) begin
                    m_ph <= 1; m_req <= int'(rd_req_dw); m_pf <= rd_prefetch;
                    m_tries <= 0; m_rcv <= 0; m_sig <= 0;
                end
                1: m_ph <= 2;
                2: if (att_valid) begin
                    int c;
                    c = want_code(int'(att_term), int'(att_dw), m_req, m_pf);
                    if (c >= 0) begin
                        m_ph <= 3; m_code <= c;
                        if (c == 4) m_rcv <= 1;
                    end else if (m_tries + 1 >= LIM) begin
                        m_ph <= 4;
                    end else begin
                        m_tries <= m_tries + 1; m_ph <= 1;
                    end
                end
                3: if (ini_query) begin
                    m_ph <= 0;
                    if (m_code == 4) m_sig <= 1;
                end
                default: m_ph <= 0;
            endcase
        end
    end

    always begin
        @(posedge clk);
        #15;
        if (rst_n && !finished) begin
            int e_resp;
            e_resp = (m_ph == 1 || m_ph == 2) ? 1 : (m_ph == 3 ? m_code : 0);
            chk(att_launch == (m_ph == 1), "R2 launch", att_launch, m_ph == 1);
            chk(int'(ini_resp) == e_resp, "R10 resp", ini_resp, e_resp);
            chk(entry_free == (m_ph == 4 || (m_ph == 3 && ini_query)), "R8 free",
                entry_free, (m_ph == 4 || (m_ph == 3 && ini_query)));
            chk(serr_out == (m_ph == 4 && cfg_serr_en && !cfg_nodeliv_dis), "R9 serr",
                serr_out, (m_ph == 4 && cfg_serr_en && !cfg_nodeliv_dis));
            chk(st_rcv_tabort == m_rcv, "R7 rcv", st_rcv_tabort, m_rcv);
            chk(st_sig_tabort == m_sig, "R7 sig", st_sig_tabort, m_sig);
        end
    end

    task automatic do_start(input int req, input bit pf);
        @(negedge clk);
        rd_start = 1'b1; rd_req_dw = DW'(req); rd_prefetch = pf;
        @(negedge clk);
        rd_start = 1'b0;
        chk(att_launch == 1'b1, "R2 launch after start", att_launch, 1);
    endtask

    task automatic attempt(input int term, input int dw);
        @(negedge clk);
        att_valid = 1'b1; att_term = 3'(term); att_dw = DW'(dw);
        @(negedge clk);
        att_valid = 1'b0;
    endtask

    task automatic collect();
        @(negedge clk);
        ini_query = 1'b1;
        #1;
        chk(entry_free == 1'b1, "R10 free on query", entry_free, 1);
        @(negedge clk);
        ini_query = 1'b0;
        chk(ini_resp == 3'd0, "R10 none after query", ini_resp, 0);
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            finished = 1;
            bad++; total++;
            $display("FAIL watchdog: actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(ini_resp == 3'd0 && !att_launch && !entry_free && !serr_out
            && !st_rcv_tabort && !st_sig_tabort, "R1 reset", ini_resp, 0);
        rst_n = 1'b1;

        // R4 prefetchable normal, all data
        do_start(8, 1);
        attempt(0, 8);
        chk(ini_resp == 3'd2, "R4 pf full -> done", ini_resp, 2);
        chk(att_launch == 1'b0, "R3 no launch after final", att_launch, 0);
        collect();

        // R4 prefetchable normal, short
        do_start(8, 1);
        attempt(0, 3);
        chk(ini_resp == 3'd3, "R4 pf short -> disc", ini_resp, 3);
        collect();

        // R5 non-prefetchable normal
        do_start(1, 0);
        attempt(0, 1);
        chk(ini_resp == 3'd3, "R5 nonpf -> disc", ini_resp, 3);
        collect();

        // R2/R6 retries then disconnect with short data
        do_start(4, 1);
        attempt(1, 0);
        chk(att_launch == 1'b1, "R2 relaunch after retry", att_launch, 1);
        attempt(2, 0);
        chk(att_launch == 1'b1, "R2 zero-data disconnect is retry", att_launch, 1);
        attempt(2, 2);
        chk(ini_resp == 3'd3, "R6 disc short -> disc", ini_resp, 3);
        collect();

        // R6 disconnect, target gave enough
        do_start(2, 0);
        attempt(2, 5);
        chk(ini_resp == 3'd2, "R6 disc enough -> done", ini_resp, 2);
        collect();

        // R7 target abort, R11 stray start and att_valid in HOLD
        do_start(4, 1);
        attempt(4, 0);
        chk(ini_resp == 3'd4, "R7 tabort code", ini_resp, 4);
        chk(st_rcv_tabort == 1'b1 && st_sig_tabort == 1'b0, "R7 rcv only", st_sig_tabort, 0);
        @(negedge clk); rd_start = 1'b1;
        @(negedge clk); rd_start = 1'b0;
        chk(ini_resp == 3'd4 && !att_launch, "R11 start ignored in hold", ini_resp, 4);
        attempt(3, 0);
        chk(ini_resp == 3'd4, "R11 att_valid ignored in hold", ini_resp, 4);
        collect();
        chk(st_sig_tabort == 1'b1 && st_rcv_tabort == 1'b1, "R7 sig after collect", st_sig_tabort, 1);
        do_start(3, 1);
        chk(!st_sig_tabort && !st_rcv_tabort, "R7 flags cleared", st_sig_tabort, 0);

        // R8 master abort
        attempt(3, 0);
        chk(ini_resp == 3'd5, "R8 mabort code", ini_resp, 5);
        collect();

        // R9 budget exhausted, error enabled
        do_start(4, 1);
        for (int k = 0; k < LIM; k++) attempt(1, 0);
        chk(serr_out == 1'b1 && entry_free == 1'b1, "R9 serr on limit", serr_out, 1);
        @(negedge clk);
        chk(!att_launch && ini_resp == 3'd0, "R9 no relaunch", att_launch, 0);

        // R9 disable bit set
        cfg_nodeliv_dis = 1'b1;
        do_start(4, 1);
        for (int k = 0; k < LIM; k++) attempt(1, 0);
        chk(serr_out == 1'b0 && entry_free == 1'b1, "R9 serr suppressed", serr_out, 0);

        // R9 enable clear
        cfg_nodeliv_dis = 1'b0; cfg_serr_en = 1'b0;
        do_start(4, 1);
        for (int k = 0; k < LIM; k++) attempt(1, 0);
        chk(serr_out == 1'b0 && entry_free == 1'b1, "R9 serr disabled", serr_out, 0);

        // R11 att_valid while idle
        attempt(0, 4);
        chk(ini_resp == 3'd0 && !att_launch, "R11 att_valid ignored idle", ini_resp, 0);

        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule